// File: doc/BRIEF.md
# Emulator Shifter with Carry and Skip Evaluation

This block sits beside the ALU of a microcoded processor that emulates a 16-bit minicomputer. It takes the L register and produces a shifted copy of it: passed through unchanged, shifted left by one, shifted right by one, or byte-swapped. The bit that enters at the open end of a one-place shift depends on a mode select. Normal mode fills with zero. Magic mode fills from the far end of T, so a double-word shift can be built from L and T. Arithmetic-emulation mode fills with a carry-in computed from the stored emulator carry and the instruction's two-bit carry field.

In emulation mode the block also works out the carry that the emulated instruction produces. It evaluates that instruction's skip condition, which can be carry clear, result zero, or both, optionally inverted. When the emulation strobe is asserted, the carry and the skip flag are captured in registers. The instruction's noload bit prevents both the carry update and the write-back of the shifted result. Zero and sign status of the shifter result are always available for microcode branches.

Top module: `emu_shift_skip`

## Requirements
- R1: When `shf_sel` = 3, `sh_out` is L rotated by 8 bits: the low byte of L moves to the high byte and the high byte moves to the low byte.
- R2: When `shf_sel` = 1 (left by one), `sh_out` is `{l_in[14:0], fill}`. The fill bit is `t_in[15]` in magic mode (`mode` = 1), the carry-in in emulation mode (`mode` = 2), and 0 in normal mode (`mode` = 0 or 3).
- R3: When `shf_sel` = 2 (right by one), `sh_out` is `{fill, l_in[15:1]}`. The fill bit is `t_in[0]` in magic mode, the carry-in in emulation mode, and 0 otherwise.
- R4: The carry-in is `carry_q` XOR a base value chosen by `cy_fld`: 0 gives `alu_cy`, 1 gives 0, 2 gives 1, and 3 gives the inverse of `alu_cy`.
- R5: `cy_next` depends on the mode. In emulation mode it is `l_in[15]` for a left shift, `l_in[0]` for a right shift, and the carry-in for pass-through or swap. In every other mode it is `alu_cy`.
- R6: The skip condition is chosen by `skc`: 0 never, 1 when `cy_next` is 0, 2 when `sh_out` is zero, and 3 when either of those holds. The result is then XORed with `skp`.
- R7: On a clock edge with `strobe` high in emulation mode, `skip_q` takes the skip condition of R6. If `noload` is also 0, `carry_q` takes `cy_next`.
- R8: `carry_q` and `skip_q` hold their values when `strobe` is low, when the mode is not emulation, and (for `carry_q` only) when `noload` is 1.
- R9: `wb_en` is 0 exactly when the mode is emulation and `noload` is 1. It is 1 in every other case.
- R10: `sh_zero` is 1 exactly when `sh_out` equals zero, and `sh_neg` equals `sh_out[15]`.
- R11: When `shf_sel` = 0, `sh_out` equals `l_in`.
- R12: While `rst_n` is low, `carry_q` and `skip_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_in | input | 16 | L register value to shift |
| t_in | input | 16 | T register value; supplies the fill bit in magic mode |
| alu_cy | input | 1 | Carry from the current ALU operation |
| shf_sel | input | 2 | Shift select: 0 pass, 1 left, 2 right, 3 byte swap |
| mode | input | 2 | Mode: 0 normal, 1 magic, 2 emulation, 3 normal |
| cy_fld | input | 2 | Carry field of the emulated instruction |
| noload | input | 1 | No-load bit of the emulated instruction |
| skc | input | 2 | Skip condition code |
| skp | input | 1 | Skip sense bit |
| strobe | input | 1 | Capture carry and skip in emulation mode |
| sh_out | output | 16 | Shifter result |
| cy_next | output | 1 | Effective carry-out |
| wb_en | output | 1 | Shifter result may be written back |
| carry_q | output | 1 | Stored emulator carry |
| skip_q | output | 1 | Registered skip flag |
| sh_zero | output | 1 | Shifter result equals zero |
| sh_neg | output | 1 | Shifter result bit 15 |

## Verification
The assertions assume that all inputs settle before each rising edge, so the `$past` values of `cy_next` and of the select fields describe the cycle that was captured. They also assume that `strobe` means nothing outside emulation mode, so a mode of 3 is treated like normal mode. The stimulus changes inputs only at falling edges. It keeps `strobe` high for exactly one edge per case, and it sets the stored carry before each case by using an emulation-mode left shift whose outgoing bit is known.

// File: rtl/emu_shift_skip.sv
module emu_shift_skip #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] l_in,
  input  logic [W-1:0] t_in,
  input  logic         alu_cy,
  input  logic [1:0]   shf_sel,
  input  logic [1:0]   mode,
  input  logic [1:0]   cy_fld,
  input  logic         noload,
  input  logic [1:0]   skc,
  input  logic         skp,
  input  logic         strobe,
  output logic [W-1:0] sh_out,
  output logic         cy_next,
  output logic         wb_en,
  output logic         carry_q,
  output logic         skip_q,
  output logic         sh_zero,
  output logic         sh_neg
);
  localparam int H = W / 2;

  logic emu, magic, base, cin, fill_l, fill_r, skip_now, upd;

  assign emu   = (mode == 2'd2);
  assign magic = (mode == 2'd1);

  always_comb begin
    case (cy_fld)
      2'd0:    base = alu_cy;
      2'd1:    base = 1'b0;
      2'd2:    base = 1'b1;
      default: base = ~alu_cy;
    endcase
  end

  assign cin    = carry_q ^ base;
  assign fill_l = magic ? t_in[W-1] : (emu ? cin : 1'b0);
  assign fill_r = magic ? t_in[0]   : (emu ? cin : 1'b0);

  always_comb begin
    case (shf_sel)
      2'd0:    sh_out = l_in;
      2'd1:    sh_out = {l_in[W-2:0], fill_l};
      2'd2:    sh_out = {fill_r, l_in[W-1:1]};
      default: sh_out = {l_in[H-1:0], l_in[W-1:H]};
    endcase
  end

  always_comb begin
    if (!emu)                 cy_next = alu_cy;
    else if (shf_sel == 2'd1) cy_next = l_in[W-1];
    else if (shf_sel == 2'd2) cy_next = l_in[0];
    else                      cy_next = cin;
  end

  assign sh_zero = (sh_out == '0);
  assign sh_neg  = sh_out[W-1];
  assign wb_en   = ~(emu & noload);

  always_comb begin
    case (skc)
      2'd0:    skip_now = skp;
      2'd1:    skip_now = skp ^ ~cy_next;
      2'd2:    skip_now = skp ^ sh_zero;
      default: skip_now = skp ^ (sh_zero | ~cy_next);
    endcase
  end

  assign upd = strobe & emu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      skip_q  <= 1'b0;
    end else if (upd) begin
      skip_q <= skip_now;
      if (!noload) carry_q <= cy_next;
    end
  end
endmodule

// File: rtl/emu_shift_skip_chk.sv
module emu_shift_skip_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] l_in,
  input logic [W-1:0] t_in,
  input logic         alu_cy,
  input logic [1:0]   shf_sel,
  input logic [1:0]   mode,
  input logic [1:0]   skc,
  input logic         skp,
  input logic         noload,
  input logic         strobe,
  input logic [W-1:0] sh_out,
  input logic         cy_next,
  input logic         wb_en,
  input logic         carry_q,
  input logic         skip_q
);
  localparam int H = W / 2;

  p_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shf_sel == 2'd3 |-> sh_out == {l_in[H-1:0], l_in[W-1:H]});

  p_magic_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_sel == 2'd1 && mode == 2'd1) |-> sh_out[0] == t_in[W-1]);

  p_magic_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_sel == 2'd2 && mode == 2'd1) |-> sh_out[W-1] == t_in[0]);

  p_plain_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd2 |-> cy_next == alu_cy);

  p_skip_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode == 2'd2 && skc == 2'd0) |=> skip_q == $past(skp));

  p_carry_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode == 2'd2 && !noload) |=> carry_q == $past(cy_next));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && mode == 2'd2) |=> ($stable(carry_q) && $stable(skip_q)));

  p_noload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && noload) |=> $stable(carry_q));

  p_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> wb_en);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shf_sel == 2'd0 |-> sh_out == l_in);
endmodule

bind emu_shift_skip emu_shift_skip_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_in(l_in), .t_in(t_in), .alu_cy(alu_cy),
  .shf_sel(shf_sel), .mode(mode), .skc(skc), .skp(skp), .noload(noload),
  .strobe(strobe), .sh_out(sh_out), .cy_next(cy_next), .wb_en(wb_en),
  .carry_q(carry_q), .skip_q(skip_q)
);

// File: tb/emu_shift_skip_test.sv
module emu_shift_skip_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] l_in = '0, t_in = '0;
  logic        alu_cy = 1'b0, noload = 1'b0, skp = 1'b0, strobe = 1'b0;
  logic [1:0]  shf_sel = '0, mode = '0, cy_fld = '0, skc = '0;
  logic [15:0] sh_out;
  logic        cy_next, wb_en, carry_q, skip_q, sh_zero, sh_neg;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  emu_shift_skip uut (
    .clk(clk), .rst_n(rst_n), .l_in(l_in), .t_in(t_in), .alu_cy(alu_cy),
    .shf_sel(shf_sel), .mode(mode), .cy_fld(cy_fld), .noload(noload),
    .skc(skc), .skp(skp), .strobe(strobe), .sh_out(sh_out),
    .cy_next(cy_next), .wb_en(wb_en), .carry_q(carry_q), .skip_q(skip_q),
    .sh_zero(sh_zero), .sh_neg(sh_neg)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s: actual %h expected %h (shf=%0d mode=%0d fld=%0d l=%h)",
                 req, act, exp, shf_sel, mode, cy_fld, l_in);
    end
  endtask

  // Sets the stored carry to v through an emulation-mode left shift (R5, R7).
  task automatic preload(input logic v);
    @(negedge clk);
    mode = 2'd2; shf_sel = 2'd1; noload = 1'b0; skc = 2'd0; skp = 1'b0;
    l_in = {v, 15'h0}; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  logic [15:0] lp [4] = '{16'h0000, 16'h8001, 16'h1234, 16'h7FFE};
  logic [15:0] tp [4] = '{16'h8000, 16'h0001, 16'hFFFF, 16'h0000};

  initial begin
    repeat (2) @(negedge clk);
    chk("R12 carry reset", {15'h0, carry_q}, 16'h0);
    chk("R12 skip reset", {15'h0, skip_q}, 16'h0);
    rst_n = 1'b1;
    for (int cq = 0; cq < 2; cq++)
      for (int p = 0; p < 4; p++)
        for (int sh = 0; sh < 4; sh++)
          for (int md = 0; md < 4; md++)
            for (int fl = 0; fl < 4; fl++)
              for (int ac = 0; ac < 2; ac++)
                for (int sc = 0; sc < 4; sc++)
                  for (int sk = 0; sk < 2; sk++)
                    for (int nl = 0; nl < 2; nl++) begin
                      logic base, cin, fill, ecy, z, skx, emu, st;
                      logic [15:0] esh;
                      st = ((md + fl + sc + sk + ac) % 3) != 0;
                      preload(cq[0]);
                      l_in = lp[p]; t_in = tp[p]; alu_cy = ac[0];
                      shf_sel = sh[1:0]; mode = md[1:0]; cy_fld = fl[1:0];
                      skc = sc[1:0]; skp = sk[0]; noload = nl[0];
                      #1;
                      emu  = (md == 2);
                      base = (fl == 0) ? ac[0] : (fl == 1) ? 1'b0 : (fl == 2) ? 1'b1 : ~ac[0];
                      cin  = cq[0] ^ base;
                      case (sh)
                        0: begin esh = lp[p]; chk("R11 pass", sh_out, esh); end
                        1: begin
                             fill = (md == 1) ? tp[p][15] : emu ? cin : 1'b0;
                             esh = (lp[p] << 1) | {15'h0, fill};
                             chk("R2 left shift", sh_out, esh);
                           end
                        2: begin
                             fill = (md == 1) ? tp[p][0] : emu ? cin : 1'b0;
                             esh = (lp[p] >> 1) | {fill, 15'h0};
                             chk("R3 right shift", sh_out, esh);
                           end
                        default: begin
                             esh = (lp[p] << 8) | (lp[p] >> 8);
                             chk("R1 byte swap", sh_out, esh);
                           end
                      endcase
                      if (!emu) ecy = ac[0];
                      else if (sh == 1) ecy = lp[p][15];
                      else if (sh == 2) ecy = lp[p][0];
                      else ecy = cin;
                      chk(emu ? "R4 R5 emulation carry" : "R5 plain carry", {15'h0, cy_next}, {15'h0, ecy});
                      chk("R9 write-back", {15'h0, wb_en}, {15'h0, ~(emu & nl[0])});
                      z = (esh == 16'h0);
                      chk("R10 zero", {15'h0, sh_zero}, {15'h0, z});
                      chk("R10 sign", {15'h0, sh_neg}, {15'h0, esh[15]});
                      skx = (sc == 0) ? 1'b0 : (sc == 1) ? ~ecy : (sc == 2) ? z : (z | ~ecy);
                      skx = skx ^ sk[0];
                      strobe = st;
                      @(negedge clk);
                      strobe = 1'b0;
                      if (st && emu) begin
                        chk("R6 R7 skip capture", {15'h0, skip_q}, {15'h0, skx});
                        chk(nl[0] ? "R8 noload holds carry" : "R7 carry capture",
                            {15'h0, carry_q}, {15'h0, nl[0] ? cq[0] : ecy});
                      end else begin
                        chk("R8 skip hold", {15'h0, skip_q}, 16'h0);
                        chk("R8 carry hold", {15'h0, carry_q}, {15'h0, cq[0]});
                      end
                    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (190000) @(posedge clk);
    join_any
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule